// File: doc/BRIEF.md
# Descriptor Prefetch FIFO with Burst Refill

This block keeps a small local queue of one-dword transmit descriptors filled from a ring of descriptors held in host memory. The host advances a write index into the ring as it posts work; the block owns the matching read index. A DMA engine takes descriptors from the block's consumer port one at a time, in the order the host posted them.

In burst mode the block waits until the local queue has drained to a low-water mark, then works out how many descriptors the host has posted that have not yet been fetched. It issues one read request to the bus master for the smaller of that number and the free space in the local queue. When the ring holds nothing, it issues no request, waits a fixed back-off and then looks again. With burst mode off, it requests exactly one descriptor whenever the queue has room.

The bus master is modelled as a request (start index and length, held until accepted) followed by that many returned dwords, which may arrive with gaps between them. A flush control empties the local queue.

Top module: `desc_prefetch`

## Requirements
- R1: While reset is high and in the first cycle after it, `desc_valid`, `req_valid` and `qread_pulse` are 0 and `rd_ptr` is 0.
- R2: The local queue holds up to DEPTH (16) descriptors of 32 bits and never more. `desc_data` presents the oldest one whenever `desc_valid` is 1, and `pop` removes it, so descriptors leave in the order they were returned by the bus.
- R3: With `burst_en` = 1, a request is issued only if the queue occupancy was at most LOW_MARK (4) in the cycle the decision was made.
- R4: With `burst_en` = 1, `req_len` equals min(DEPTH − occupancy, (host_wr_ptr − rd_ptr) mod 2^RING_AW), taken at the decision cycle.
- R5: When the refill condition holds but the ring is empty, no request is issued. The block waits 16 cycles before it samples `host_wr_ptr` again, so a request appears at most 19 cycles after descriptors are posted.
- R6: In the cycle after the last returned dword is accepted, `rd_ptr` has advanced by `req_len` modulo the ring size and `qread_pulse` is 1 for exactly one cycle. `rd_ptr` changes at no other time.
- R7: With `burst_en` = 0, every request has `req_len` = 1, and one is issued whenever the queue is not full and the ring is not empty.
- R8: A cycle with `flush` = 1 discards every descriptor held, so `desc_valid` is 0 in the next cycle. While `flush` is 1 no new request starts and `pop` has no effect.
- R9: `req_valid` stays high with `req_start` and `req_len` unchanged until `req_ready` is seen. Only one request is outstanding at a time.
- R10: `req_start` equals the current `rd_ptr`. Returned dword i of a burst belongs to ring index (req_start + i) mod 2^RING_AW, so a burst may cross the ring end and `rd_ptr` wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_en | input | 1 | 1 selects batched refill at the low-water mark, 0 selects single-descriptor fetch |
| flush | input | 1 | Discards the queue contents while high |
| host_wr_ptr | input | RING_AW | Host ring write index |
| rd_ptr | output | RING_AW | Ring read index owned by the block |
| req_valid | output | 1 | Burst read request pending |
| req_ready | input | 1 | Bus master accepts the request |
| req_start | output | RING_AW | First ring index of the request |
| req_len | output | $clog2(DEPTH+1) | Number of dwords requested |
| rsp_valid | input | 1 | Returned dword valid |
| rsp_data | input | DW | Returned descriptor |
| pop | input | 1 | Consumer removes the head descriptor |
| desc_valid | output | 1 | Head descriptor valid |
| desc_data | output | DW | Head descriptor |
| qread_pulse | output | 1 | One-cycle pulse per completed ring read |

## Verification
The properties check on every cycle that occupancy stays bounded, that a burst never asks for more than the free space, and that refill starts only under the low-water mark. They also check that requests hold steady until accepted, that the read index moves only together with the completion pulse, and that flush both empties the queue and blocks new requests. Other behaviour shows only across scenarios. These are the exact burst length from the ring fill level, the data order through ring wrap, the back-off delay after an empty ring, and the resumption after a flush. A bench scoreboard that models the host ring and the queue covers them.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_DATA
  } fetch_state_t;
endpackage

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic do_push, do_pop;

  assign do_push = push && !flush && (count < CW'(DEPTH));
  assign do_pop  = pop && !flush && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_idx <= wr_idx + 1'b1;
      if (do_pop)  rd_idx <= rd_idx + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_idx];
endmodule

// File: rtl/burst_sizer.sv
module burst_sizer #(
  parameter int RING_AW = 6,
  parameter int DEPTH   = 16,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int MW     = ((RING_AW > CW) ? RING_AW : CW) + 1
) (
  input  logic               burst_en,
  input  logic [RING_AW-1:0] wr_ptr,
  input  logic [RING_AW-1:0] rd_ptr,
  input  logic [CW-1:0]      count,
  output logic               avail_any,
  output logic [CW-1:0]      len
);
  logic [RING_AW-1:0] avail;
  logic [MW-1:0]      avail_x, free_x, pick;

  assign avail     = wr_ptr - rd_ptr;
  assign avail_any = (avail != '0);
  assign avail_x   = MW'(avail);
  assign free_x    = MW'(CW'(DEPTH) - count);
  assign pick      = (avail_x < free_x) ? avail_x : free_x;
  assign len       = burst_en ? CW'(pick) : CW'(1);
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import dp_pkg::*;
#(
  parameter int RING_AW  = 6,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 4,
  parameter int BACKOFF  = 16,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int BW      = $clog2(BACKOFF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               burst_en,
  input  logic               flush,
  input  logic [CW-1:0]      count,
  input  logic               avail_any,
  input  logic [CW-1:0]      len,
  input  logic               req_ready,
  input  logic               rsp_valid,
  output logic               req_valid,
  output logic [RING_AW-1:0] req_start,
  output logic [CW-1:0]      req_len,
  output logic [RING_AW-1:0] rd_ptr,
  output logic               push,
  output logic               qread_pulse
);
  fetch_state_t  state;
  logic [BW-1:0] bo_cnt;
  logic [CW-1:0] beat_cnt;
  logic          trigger, last_beat;

  assign trigger   = !flush && (burst_en ? (count <= CW'(LOW_MARK))
                                         : (count < CW'(DEPTH)));
  assign last_beat = (beat_cnt == req_len - 1'b1);
  assign push      = (state == ST_DATA) && rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_valid   <= 1'b0;
      req_start   <= '0;
      req_len     <= '0;
      rd_ptr      <= '0;
      qread_pulse <= 1'b0;
      bo_cnt      <= '0;
      beat_cnt    <= '0;
    end else begin
      qread_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            if (avail_any) begin
              state     <= ST_REQ;
              req_valid <= 1'b1;
              req_start <= rd_ptr;
              req_len   <= len;
            end else begin
              state  <= ST_WAIT;
              bo_cnt <= BW'(BACKOFF - 1);
            end
          end
        end
        ST_WAIT: begin
          if (bo_cnt == '0) state <= ST_IDLE;
          else              bo_cnt <= bo_cnt - 1'b1;
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            beat_cnt  <= '0;
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rsp_valid) begin
            if (last_beat) begin
              rd_ptr      <= rd_ptr + RING_AW'(req_len);
              qread_pulse <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              beat_cnt <= beat_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_prefetch.sv
module desc_prefetch #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 4,
  parameter int RING_AW  = 6,
  parameter int BACKOFF  = 16,
  localparam int LEN_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               burst_en,
  input  logic               flush,
  input  logic [RING_AW-1:0] host_wr_ptr,
  output logic [RING_AW-1:0] rd_ptr,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [RING_AW-1:0] req_start,
  output logic [LEN_W-1:0]   req_len,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_data,
  input  logic               pop,
  output logic               desc_valid,
  output logic [DW-1:0]      desc_data,
  output logic               qread_pulse
);
  logic [LEN_W-1:0] fifo_cnt;
  logic [LEN_W-1:0] next_len;
  logic             avail_any;
  logic             fifo_push;

  desc_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (fifo_push),
    .push_data (rsp_data),
    .pop       (pop),
    .out_valid (desc_valid),
    .out_data  (desc_data),
    .count     (fifo_cnt)
  );

  burst_sizer #(.RING_AW(RING_AW), .DEPTH(DEPTH)) sizer_i (
    .burst_en  (burst_en),
    .wr_ptr    (host_wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (fifo_cnt),
    .avail_any (avail_any),
    .len       (next_len)
  );

  refill_ctrl #(
    .RING_AW(RING_AW), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .BACKOFF(BACKOFF)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .burst_en    (burst_en),
    .flush       (flush),
    .count       (fifo_cnt),
    .avail_any   (avail_any),
    .len         (next_len),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .req_valid   (req_valid),
    .req_start   (req_start),
    .req_len     (req_len),
    .rd_ptr      (rd_ptr),
    .push        (fifo_push),
    .qread_pulse (qread_pulse)
  );
endmodule

// File: rtl/desc_prefetch_chk.sv
module desc_prefetch_chk #(
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 4,
  parameter int RING_AW  = 6,
  localparam int LEN_W   = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               burst_en,
  input logic               flush,
  input logic               req_valid,
  input logic               req_ready,
  input logic [RING_AW-1:0] req_start,
  input logic [LEN_W-1:0]   req_len,
  input logic [RING_AW-1:0] rd_ptr,
  input logic               qread_pulse,
  input logic               desc_valid,
  input logic [LEN_W-1:0]   fifo_cnt
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= LEN_W'(DEPTH));

  p_len_fits_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> (int'(req_len) <= DEPTH - int'($past(fifo_cnt))));

  p_low_mark_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && $past(burst_en)) |-> ($past(fifo_cnt) <= LEN_W'(LOW_MARK)));

  p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0 && req_len <= LEN_W'(DEPTH)));

  p_ptr_moves_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr != $past(rd_ptr)) |-> qread_pulse);

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (rst)
    qread_pulse |=> !qread_pulse);

  p_single_len_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && !$past(burst_en)) |-> (req_len == LEN_W'(1)));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !desc_valid);

  p_flush_noreq_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> !$past(flush));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_start) && $stable(req_len)));

  p_req_start_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_start == rd_ptr));
endmodule

bind desc_prefetch desc_prefetch_chk #(
  .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .RING_AW(RING_AW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .burst_en    (burst_en),
  .flush       (flush),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_start   (req_start),
  .req_len     (req_len),
  .rd_ptr      (rd_ptr),
  .qread_pulse (qread_pulse),
  .desc_valid  (desc_valid),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/desc_prefetch_tb_top.sv
module desc_prefetch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEPTH = 16, LOW_MARK = 4, RING_AW = 6, BACKOFF = 16;
  localparam int RSZ = 1 << RING_AW;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic burst_en = 0, flush = 0, req_ready = 0, rsp_valid = 0, pop = 0;
  logic [RING_AW-1:0] host_wr_ptr = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [RING_AW-1:0] rd_ptr, req_start;
  logic [LEN_W-1:0] req_len;
  logic req_valid, desc_valid, qread_pulse;
  logic [DW-1:0] desc_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_prefetch #(.DW(DW), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK),
                  .RING_AW(RING_AW), .BACKOFF(BACKOFF)) dut_i (
    .clk(clk), .rst(rst), .burst_en(burst_en), .flush(flush),
    .host_wr_ptr(host_wr_ptr), .rd_ptr(rd_ptr), .req_valid(req_valid),
    .req_ready(req_ready), .req_start(req_start), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pop(pop),
    .desc_valid(desc_valid), .desc_data(desc_data), .qread_pulse(qread_pulse));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] ring [RSZ];
  logic [DW-1:0] mq [$];
  int wr_i = 0, exp_rd = 0;
  int cnt_prev = 0, wr_prev = 0;
  bit burst_prev = 0;
  bit req_seen = 0, acc_pend = 0, sending = 0;
  int cur_len = 0, cur_start = 0, sent = 0;
  bit burst_cmd = 0, flush_cmd = 0, post_on = 0;
  int pop_mode = 0, post_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(int wr, int rd, int cnt, bit be);
    int avail = (wr - rd) & (RSZ - 1);
    int free  = DEPTH - cnt;
    if (!be) return 1;
    return (avail < free) ? avail : free;
  endfunction

  function automatic int unread();
    return (wr_i - exp_rd) & (RSZ - 1);
  endfunction

  task automatic step();
    bit do_pop;
    @(negedge clk);
    // scoreboard on outputs after the last edge
    chk(desc_valid == (mq.size() != 0), "R2", "desc_valid", desc_valid, mq.size() != 0);
    if (desc_valid && mq.size() != 0)
      chk(desc_data == mq[0], "R2", "head data", desc_data, mq[0]);
    if (req_valid && !req_seen) begin
      req_seen = 1;
      chk(int'(req_len) == exp_len(wr_prev, exp_rd, cnt_prev, burst_prev),
          burst_prev ? "R4" : "R7", "req_len", req_len,
          exp_len(wr_prev, exp_rd, cnt_prev, burst_prev));
      chk(int'(req_start) == exp_rd, "R10", "req_start", req_start, exp_rd);
      if (burst_prev) chk(cnt_prev <= LOW_MARK, "R3", "occupancy at request", cnt_prev, LOW_MARK);
      cur_len = req_len;
      cur_start = req_start;
    end
    if (qread_pulse) begin
      exp_rd = (exp_rd + cur_len) & (RSZ - 1);
      chk(int'(rd_ptr) == exp_rd, "R6", "rd_ptr after burst", rd_ptr, exp_rd);
      chk(!sending && req_seen, "R6", "pulse after last beat", sending, 0);
      req_seen = 0;
    end
    // drive inputs for the next edge
    burst_en = burst_cmd;
    flush = flush_cmd;
    if (acc_pend) begin sending = 1; sent = 0; acc_pend = 0; end
    req_ready = 0;
    if (req_valid && !sending) begin
      req_ready = ($urandom % 3 == 0);
      if (req_ready) acc_pend = 1;
    end
    rsp_valid = 0;
    if (sending && ($urandom % 4 != 0)) begin
      rsp_valid = 1;
      rsp_data = ring[(cur_start + sent) & (RSZ - 1)];
      sent++;
      if (sent == cur_len) sending = 0;
    end
    do_pop = 0;
    if (desc_valid && !flush_cmd)
      do_pop = (pop_mode == 2) || (pop_mode == 1 && $urandom % 3 == 0);
    pop = do_pop;
    if (post_on && $urandom % 6 == 0) post_n += 1 + $urandom % 5;
    while (post_n > 0 && unread() < RSZ - 4) begin
      ring[wr_i] = $urandom;
      wr_i = (wr_i + 1) & (RSZ - 1);
      post_n--;
    end
    post_n = 0;
    host_wr_ptr = RING_AW'(wr_i);
    cnt_prev = mq.size();
    wr_prev = wr_i;
    burst_prev = burst_en;
    if (flush) mq.delete();
    else begin
      if (do_pop) void'(mq.pop_front());
      if (rsp_valid) mq.push_back(rsp_data);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!desc_valid && !req_valid && !qread_pulse && rd_ptr == 0, "R1", "outputs in reset",
        {desc_valid, req_valid, qread_pulse}, 0);
    rst = 0;
    @(negedge clk);
    chk(!desc_valid && !req_valid && !qread_pulse && rd_ptr == 0, "R1", "outputs after reset",
        {desc_valid, req_valid, qread_pulse}, 0);
    // random burst traffic, ring wraps many times (R2 R3 R4 R6 R9 R10)
    burst_cmd = 1; post_on = 1; pop_mode = 1;
    repeat (4000) step();
    // R5 empty ring and back-off
    post_on = 0; pop_mode = 2;
    n = 0;
    while ((mq.size() != 0 || req_seen || sending || acc_pend || unread() != 0) && n < 2000) begin
      step(); n++;
    end
    repeat (30) step();
    for (int i = 0; i < 40; i++) begin
      step();
      if (req_valid) chk(0, "R5", "request on empty ring", 1, 0);
    end
    chk(!req_seen, "R5", "no request while ring empty", req_seen, 0);
    post_n = 3;
    n = 0;
    while (!req_seen && n < 40) begin step(); n++; end
    chk(n >= 1 && n <= BACKOFF + 3, "R5", "cycles to request after post", n, BACKOFF + 3);
    chk(cur_len == 3, "R5", "length after back-off", cur_len, 3);
    repeat (60) step();
    // R7 single fetch mode
    burst_cmd = 0; post_on = 1; pop_mode = 1;
    repeat (2000) step();
    // R8 flush with a full queue
    post_on = 0; pop_mode = 0; burst_cmd = 1;
    n = 0;
    while ((req_seen || sending || acc_pend) && n < 500) begin step(); n++; end
    post_n = 40;
    n = 0;
    while (!(mq.size() == DEPTH && !req_seen && !sending && !acc_pend) && n < 2000) begin
      step(); n++;
    end
    chk(mq.size() == DEPTH, "R2", "queue fills to depth", mq.size(), DEPTH);
    flush_cmd = 1;
    step();
    step();
    chk(!desc_valid, "R8", "empty after flush", desc_valid, 0);
    for (int i = 0; i < 12; i++) begin
      step();
      if (req_valid) chk(0, "R8", "request during flush", 1, 0);
    end
    chk(int'(rd_ptr) == exp_rd, "R8", "rd_ptr kept by flush", rd_ptr, exp_rd);
    chk(unread() > 0, "R8", "descriptors waiting", unread(), 1);
    flush_cmd = 0;
    n = 0;
    while (!req_seen && n < 10) begin step(); n++; end
    chk(req_seen, "R8", "refill resumes after flush", req_seen, 1);
    pop_mode = 2;
    repeat (300) step();
    // R10 wrap: final mixed traffic
    post_on = 1; pop_mode = 1;
    repeat (1500) step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule